// File: doc/BRIEF.md
# Region-Selectable ECC Write-Merge Path

This block sits between a host data port and a storage array. It decides, word by word, whether a location is guarded by error correction. The address space is split into equal regions by the top address bits. A run-time mode register holds one bit per region, and a set bit makes that region protected. Protected words are stored as 64 data bits plus 8 check bits of an extended Hamming code. On read they are checked and corrected in the same cycle the array returns them, and a single-error or double-error flag is raised. Unprotected regions behave as plain memory.

A write that enables only some byte lanes cannot be written straight into a protected word, because its check bits cover the whole word. Such a write becomes an internal sequence: read the old word, correct it, merge in the enabled bytes, recompute the check bits and write back. The host port uses a ready/valid handshake and is held off while this runs. A write to the mode register is parked until no command is in flight. Commands are refused while a mode change is pending, so every command sees a single, well-defined mode.

The array is assumed to return read data one cycle after a read request, and to write each byte lane whose enable is set.

Top module: `ecc_merge_path`

## Requirements
- R1: After reset every region is general-purpose, req_ready is high and rsp_valid is low.
- R2: The region of an address is its top log2(REGIONS) bits. Bit r of the mode register set means region r is protected. With the defaults, address 0x1FF is in region 1 and 0x200 is in region 2.
- R3: A write to a protected word with all eight byte enables set places the data in arr_wdata[63:0] and the check bits in arr_wdata[71:64]. It enables all nine array lanes, with lane 8 being the check byte. A later error-free read returns the data with both flags low.
- R4: A read is issued to the array in the cycle it is accepted, at the same address. Its response appears on rsp_valid exactly one cycle later, and reads can be accepted on back-to-back cycles.
- R5: A protected word with any one of its 72 stored bits flipped reads back as the original data, with rsp_sec=1 and rsp_ded=0.
- R6: A protected word with two stored bits flipped reads back with rsp_ded=1 and rsp_sec=0. The returned data is the stored data bits, left uncorrected.
- R7: A write to a protected word with req_be not all ones takes three cycles. In the accept cycle the array is read. In the next cycle the array is not accessed. In the third cycle the full word is written with all nine lanes enabled. req_ready is low in the two cycles after acceptance. Byte i (bits 8i+7:8i) comes from the host when req_be[i] is set and from the old word otherwise.
- R8: In a general-purpose region a read returns the raw stored bits with both flags low. A write enables exactly the lanes in req_be, leaves the check lane disabled, never reads the array, and leaves req_ready high.
- R9: A mode register write keeps req_ready low while it is pending. It takes effect once no command is in flight, and every command accepted afterwards uses the new mode.
- R10: A single-bit error in the old word of a merge is corrected before the merge, so the word written back reads clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_mode | input | REGIONS | New per-region protection bits |
| req_valid | input | 1 | Host command valid |
| req_ready | output | 1 | Command accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables of the write |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DW | Read data, corrected when protected |
| rsp_sec | output | 1 | Single error seen and corrected |
| rsp_ded | output | 1 | Double error detected, data uncorrected |
| arr_req | output | 1 | Array access strobe |
| arr_we | output | 1 | Array write (1) or read (0) |
| arr_addr | output | AW | Array word address |
| arr_wdata | output | DW+CW | Check byte over data word |
| arr_wbe | output | DW/8+1 | Array lane enables, top lane for check bits |
| arr_rdata | input | DW+CW | Array read data, one cycle after a read |

## Verification
Two of this block's functions can fall in the same cycle. The response of a host read is decoded from the array data in the very cycle that a masked protected write is accepted and issues its own array read. A mode register write can also arrive while a merge is still running. The bench provokes the first case by issuing a read and, on the next edge, a masked write to a protected word. The response must arrive on time with the right data, and a later read of the merged word must show the host bytes over the old ones. For the second case it writes the mode register in the middle of a merge. The port must stay closed until the merge and the pending change have both finished, and later reads must follow the new protection map.

// File: rtl/ecc_merge_path.sv
module ecc_merge_path #(
  parameter int DW = 64,
  parameter int CW = 8,
  parameter int AW = 10,
  parameter int REGIONS = 4
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [REGIONS-1:0]   cfg_mode,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [DW/8-1:0]      req_be,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_data,
  output logic                 rsp_sec,
  output logic                 rsp_ded,
  output logic                 arr_req,
  output logic                 arr_we,
  output logic [AW-1:0]        arr_addr,
  output logic [DW+CW-1:0]     arr_wdata,
  output logic [DW/8:0]        arr_wbe,
  input  logic [DW+CW-1:0]     arr_rdata
);
  localparam int NB   = DW / 8;
  localparam int HB   = CW - 1;
  localparam int NPOS = DW + HB;
  localparam int RB   = $clog2(REGIONS);

  typedef enum logic [1:0] {IDLE, MERGE, WBACK} st_t;

  function automatic logic [HB-1:0] hsyn(input logic [DW-1:0] d);
    logic [HB-1:0] s;
    int k;
    s = '0;
    k = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) s = s ^ HB'(p);
        k++;
      end
    end
    return s;
  endfunction

  function automatic logic [DW-1:0] repair(input logic [DW-1:0] d, input logic [HB-1:0] s);
    logic [DW-1:0] r;
    int k;
    r = d;
    k = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p == int'(s)) r[k] = ~r[k];
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [HB-1:0] h;
    h = hsyn(d);
    return {^{d, h}, h};
  endfunction

  st_t              st;
  logic [REGIONS-1:0] mode, pend;
  logic             pflag, rd_q, prot_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wd_q, mrg_q;
  logic [NB-1:0]    be_q;

  wire [RB-1:0] reg_a  = req_addr[AW-1 -: RB];
  wire          prot_a = mode[reg_a];
  wire          acc    = req_valid && req_ready;
  wire          rmw    = acc && req_write && prot_a && !(&req_be);

  wire [DW-1:0] rd_d  = arr_rdata[DW-1:0];
  wire [HB-1:0] syn   = hsyn(rd_d) ^ arr_rdata[DW +: HB];
  wire          odd   = ^arr_rdata;
  wire [DW-1:0] fixed = odd ? repair(rd_d, syn) : rd_d;

  assign req_ready = (st == IDLE) && !pflag;
  assign rsp_valid = rd_q;
  assign rsp_data  = prot_q ? fixed : rd_d;
  assign rsp_sec   = rd_q && prot_q && odd;
  assign rsp_ded   = rd_q && prot_q && !odd && (syn != '0);

  always_comb begin
    arr_req   = 1'b0;
    arr_we    = 1'b0;
    arr_addr  = req_addr;
    arr_wdata = {enc(req_wdata), req_wdata};
    arr_wbe   = prot_a ? '1 : {1'b0, req_be};
    if (st == WBACK) begin
      arr_req   = 1'b1;
      arr_we    = 1'b1;
      arr_addr  = addr_q;
      arr_wdata = {enc(mrg_q), mrg_q};
      arr_wbe   = '1;
    end else if (acc) begin
      arr_req = 1'b1;
      arr_we  = req_write && !rmw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      mode   <= '0;
      pend   <= '0;
      pflag  <= 1'b0;
      rd_q   <= 1'b0;
      prot_q <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      be_q   <= '0;
      mrg_q  <= '0;
    end else begin
      rd_q   <= acc && !req_write;
      prot_q <= prot_a;
      case (st)
        IDLE: if (rmw) begin
          st     <= MERGE;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          be_q   <= req_be;
        end
        MERGE: begin
          st <= WBACK;
          for (int b = 0; b < NB; b++)
            mrg_q[8*b +: 8] <= be_q[b] ? wd_q[8*b +: 8] : fixed[8*b +: 8];
        end
        default: st <= IDLE;
      endcase
      if (cfg_we) begin
        pend  <= cfg_mode;
        pflag <= 1'b1;
      end else if (pflag && st == IDLE && !rd_q) begin
        mode  <= pend;
        pflag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecc_merge_path_chk.sv
module ecc_merge_path_chk #(
  parameter int DW = 64,
  parameter int AW = 10
)(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic            rsp_sec,
  input logic            rsp_ded,
  input logic            arr_req,
  input logic            arr_we,
  input logic [AW-1:0]   arr_addr,
  input logic [DW/8:0]   arr_wbe
);
  wire host_acc = req_valid && req_ready;
  wire rmw_start = host_acc && req_write && arr_req && !arr_we;

  // R4
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc && !req_write) |=> rsp_valid);

  // R4
  acc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_acc |-> (arr_req && arr_addr == req_addr));

  // R7
  rmw_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |=> (!req_ready && !arr_req));

  // R7
  rmw_wback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |=> ##1 (arr_req && arr_we && (&arr_wbe) && !req_ready));

  // R3
  check_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && arr_we && arr_wbe[DW/8]) |-> (&arr_wbe));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_sec && rsp_ded));

  // R5
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_sec || rsp_ded) |-> rsp_valid);
endmodule

bind ecc_merge_path ecc_merge_path_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/ecc_merge_path_bench.sv
module ecc_merge_path_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_mode = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0] req_be = '0;
  logic req_ready, rsp_valid, rsp_sec, rsp_ded;
  logic [63:0] rsp_data;
  logic arr_req, arr_we;
  logic [9:0] arr_addr;
  logic [71:0] arr_wdata, arr_rdata;
  logic [8:0] arr_wbe;

  always #2.5 clk = ~clk;

  ecc_merge_path u_ecc_merge_path (.*);

  typedef struct { logic [63:0] d; logic s; logic e; int cyc; string tag; } exp_t;
  exp_t q[$];
  int nchk = 0, nfail = 0, cyc = 0, nrd = 0, acc_cyc = 0;
  logic [3:0] pm = '0;
  logic [63:0] refm [int];

  logic inj_en = 1'b0;
  logic [9:0] inj_a = '0;
  logic [71:0] inj_m = '0;
  logic [71:0] mem [0:1023];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_req && !arr_we) nrd <= nrd + 1;
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else begin
      if (inj_en) mem[inj_a] <= mem[inj_a] ^ inj_m;
      if (arr_req) begin
        if (arr_we) begin
          for (int l = 0; l < 9; l++)
            if (arr_wbe[l]) mem[arr_addr][8*l +: 8] <= arr_wdata[8*l +: 8];
        end else arr_rdata <= mem[arr_addr];
      end
    end
  end

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && rsp_valid) begin
      nchk++;
      if (q.size() == 0) begin
        nfail++;
        $display("FAIL R4 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        e = q.pop_front();
        if (rsp_data !== e.d || rsp_sec !== e.s || rsp_ded !== e.e || cyc != e.cyc) begin
          nfail++;
          $display("FAIL %s actual=%h sec=%0b ded=%0b cyc=%0d expected=%h sec=%0b ded=%0b cyc=%0d",
                   e.tag, rsp_data, rsp_sec, rsp_ded, cyc, e.d, e.s, e.e, e.cyc);
        end
      end
    end
  end

  task automatic issue(input logic w, input logic [9:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    acc_cyc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [63:0] d, input logic [7:0] be);
    logic [63:0] old;
    old = refm.exists(int'(a)) ? refm[int'(a)] : 64'h0;
    issue(1'b1, a, d, be);
    refm[int'(a)] = merge(old, d, be);
  endtask

  task automatic rd(input logic [9:0] a, input logic [63:0] ed, input logic es, input logic ee, input string tag);
    exp_t e;
    issue(1'b0, a, 64'h0, 8'h0);
    e.d = ed; e.s = es; e.e = ee; e.cyc = acc_cyc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic inject(input logic [9:0] a, input logic [71:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_a = a; inj_m = m;
    @(posedge clk);
    #1 inj_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    int n0;
    logic [63:0] m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready after reset", 72'(req_ready), 72'd1);
    chk(rsp_valid === 1'b0, "R1 no response after reset", 72'(rsp_valid), 72'd0);

    // R1 R8 all regions plain after reset
    wr(10'h005, 64'hA5A5_0000_FFFF_1234, 8'hFF);
    rd(10'h005, 64'hA5A5_0000_FFFF_1234, 1'b0, 1'b0, "R1 plain read");
    inject(10'h005, (72'h1 << 66) | 72'h8);
    rd(10'h005, 64'hA5A5_0000_FFFF_123C, 1'b0, 1'b0, "R8 raw bits no flags");
    settle();

    // R9 mode write while idle
    @(negedge clk); cfg_we = 1'b1; cfg_mode = 4'b0011;
    @(posedge clk); #1 cfg_we = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b0, "R9 ready low while pending", 72'(req_ready), 72'd0);
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready after apply", 72'(req_ready), 72'd1);
    pm = 4'b0011;

    // R3 R4 protected full writes and back-to-back reads
    wr(10'h010, 64'h0123_4567_89AB_CDEF, 8'hFF);
    wr(10'h011, 64'hFEDC_BA98_7654_3210, 8'hFF);
    wr(10'h1FF, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF);
    wr(10'h012, 64'h5555_AAAA_3333_CCCC, 8'hFF);
    rd(10'h010, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, "R3 clean read 0x010");
    rd(10'h011, 64'hFEDC_BA98_7654_3210, 1'b0, 1'b0, "R4 back-to-back 0x011");
    rd(10'h1FF, 64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b0, "R4 back-to-back 0x1FF");
    settle();

    // R5 single flips in data and check bits
    inject(10'h010, 72'h1);
    inject(10'h011, 72'h1 << 63);
    inject(10'h1FF, 72'h1 << 64);
    inject(10'h012, 72'h1 << 71);
    rd(10'h010, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, "R5 flip bit0");
    rd(10'h011, 64'hFEDC_BA98_7654_3210, 1'b1, 1'b0, "R5 flip bit63");
    rd(10'h1FF, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, 1'b0, "R5 flip bit64");
    rd(10'h012, 64'h5555_AAAA_3333_CCCC, 1'b1, 1'b0, "R5 flip bit71");
    settle();

    // R6 double flips
    wr(10'h020, 64'h1111_2222_3333_4444, 8'hFF);
    wr(10'h021, 64'h9999_8888_7777_6666, 8'hFF);
    inject(10'h020, (72'h1 << 7) | (72'h1 << 40));
    inject(10'h021, (72'h1 << 2) | (72'h1 << 68));
    rd(10'h020, 64'h1111_2222_3333_4444 ^ ((64'h1 << 7) | (64'h1 << 40)), 1'b0, 1'b1, "R6 two data bits");
    rd(10'h021, 64'h9999_8888_7777_6662, 1'b0, 1'b1, "R6 data and check bit");
    settle();

    // R2 region boundary 0x1FF protected, 0x200 plain
    wr(10'h200, 64'h0F0F_0F0F_0F0F_0F0F, 8'hFF);
    inject(10'h200, 72'h1 << 10);
    rd(10'h200, 64'h0F0F_0F0F_0F0F_0F0F ^ (64'h1 << 10), 1'b0, 1'b0, "R2 region2 plain");
    rd(10'h1FF, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, 1'b0, "R2 region1 protected");
    settle();

    // R7 masked write sequence
    wr(10'h030, 64'h0102_0304_0506_0708, 8'hFF);
    settle();
    wr(10'h030, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F);
    @(negedge clk);
    chk(!req_ready && !arr_req, "R7 merge cycle idle array", {arr_req, req_ready}, 72'd0);
    @(negedge clk);
    chk(!req_ready && arr_req && arr_we && arr_wbe == 9'h1FF, "R7 writeback cycle",
        {arr_req, arr_we, arr_wbe, req_ready}, {1'b1, 1'b1, 9'h1FF, 1'b0});
    @(negedge clk);
    chk(req_ready === 1'b1, "R7 ready after sequence", 72'(req_ready), 72'd1);
    rd(10'h030, 64'h0102_0304_CCCC_DDDD, 1'b0, 1'b0, "R7 merged word");
    settle();

    // R10 merge over a single-error word
    wr(10'h010, 64'h7700_0000_0000_0000, 8'h80);
    rd(10'h010, 64'h7723_4567_89AB_CDEF, 1'b0, 1'b0, "R10 corrected merge clean");
    settle();

    // R8 plain masked write, no array read
    wr(10'h205, 64'h1122_3344_5566_7788, 8'hFF);
    settle();
    n0 = nrd;
    wr(10'h205, 64'hFFFF_FFFF_FFFF_FFFF, 8'h3C);
    @(negedge clk);
    chk(req_ready === 1'b1, "R8 no hold for plain masked write", 72'(req_ready), 72'd1);
    settle();
    chk(nrd == n0, "R8 no array read", 72'(nrd), 72'(n0));
    rd(10'h205, 64'h1122_FFFF_FFFF_7788, 1'b0, 1'b0, "R8 plain merged bytes");
    settle();

    // read response in the same cycle as a merge start
    wr(10'h031, 64'h0000_1111_2222_3333, 8'hFF);
    settle();
    rd(10'h030, 64'h0102_0304_CCCC_DDDD, 1'b0, 1'b0, "R4 read beside merge");
    wr(10'h031, 64'hEE00_0000_0000_00EE, 8'h81);
    rd(10'h031, 64'hEE00_1111_2222_33EE, 1'b0, 1'b0, "R7 merge after read");
    settle();

    // R9 mode change during a merge
    wr(10'h032, 64'h8888_8888_8888_8888, 8'hFF);
    settle();
    wr(10'h032, 64'h0000_0000_0000_0011, 8'h01);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = 4'b0010;
    @(posedge clk); #1 cfg_we = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b0, "R9 closed in writeback", 72'(req_ready), 72'd0);
    @(negedge clk);
    chk(req_ready === 1'b0, "R9 closed while pending", 72'(req_ready), 72'd0);
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 open after drain", 72'(req_ready), 72'd1);
    pm = 4'b0010;
    m = 64'h8888_8888_8888_8811;
    rd(10'h032, m, 1'b0, 1'b0, "R9 merge finished under old mode");
    inject(10'h032, 72'h20);
    rd(10'h032, m ^ 64'h20, 1'b0, 1'b0, "R9 region0 now plain");
    rd(10'h1FF, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, 1'b0, "R9 region1 still protected");
    settle();
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R4 all responses seen", 72'(q.size()), 72'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule